// File: doc/BRIEF.md
# Burst-Granular Write Buffer with Early Backpressure

This block sits between a pixel producer and the engine that writes bursts to memory. The producer offers one data word per cycle. The buffer holds these words while the memory side has no free frame slot. The memory side takes data out only as whole bursts of a fixed length. Capacity is a whole number of bursts. A high watermark, also counted in bursts, tells the producer to slow down before the store runs out.

Backpressure is advisory. The flag drops once occupancy reaches the watermark. Words are still accepted until the store is completely full. After that, incoming words are discarded, and each discarded word is recorded by a one-cycle pulse, a sticky flag and a saturating counter. A burst is drained by a small state machine with two states. `DS_IDLE` moves to `DS_DRAIN` when `drain_go` is sampled high while a full burst is stored. `DS_DRAIN` returns to `DS_IDLE` after the last beat of the burst. No other transitions exist.

Top module: `burst_fifo_wm`

## Requirements
- R1: While `rst_n` is low, the outputs take these values: `in_ready` 1, `burst_avail` 0, `out_valid` 0, `out_last` 0, `drop_pulse` 0, `drop_sticky` 0 and `drop_count` 0. After reset the store is empty.
- R2: `burst_avail` is 1 exactly when the store holds at least BURST_LEN words.
- R3: `in_ready` is 0 exactly when the stored word count is at least HWM_BURSTS×BURST_LEN, and it returns to 1 as soon as the count falls below that value.
- R4: A word offered while `in_ready` is 0 is still stored, provided the store is not full.
- R5: A word offered when the store holds DEPTH_BURSTS×BURST_LEN words, in a cycle with no drain beat, is discarded. In the following cycle `drop_pulse` is 1 and `drop_sticky` is 1. `drop_sticky` then stays 1 until reset.
- R6: Starting a drain (from `DS_IDLE` to `DS_DRAIN`) produces, from the next cycle on, exactly BURST_LEN consecutive cycles with `out_valid` 1. `out_last` is 1 only on the final cycle. `out_valid` is 0 in the cycle after the final beat.
- R7: `drain_go` has no effect while fewer than BURST_LEN words are stored. It also has no effect while a drain is in progress: holding it high neither lengthens nor restarts the current burst.
- R8: A word offered in a cycle that carries a drain beat is always stored, even when the store is full. The stored word count is then unchanged and no drop is recorded.
- R9: `drop_count` increases by one for each discarded word and saturates at 2^DROP_CNT_W−1.
- R10: Words leave on `out_data` in the order they were stored, and discarded words never appear. This order holds across any number of wraps of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word this cycle |
| in_data | input | DATA_W | Producer word |
| in_ready | output | 1 | Advisory backpressure flag; 0 means slow down |
| burst_avail | output | 1 | At least one full burst is stored |
| drain_go | input | 1 | Memory side requests one burst |
| out_valid | output | 1 | A burst beat is on `out_data` |
| out_data | output | DATA_W | Burst beat data, oldest word first |
| out_last | output | 1 | Final beat of the current burst |
| drop_pulse | output | 1 | A word was discarded in the previous cycle |
| drop_sticky | output | 1 | At least one word was discarded since reset |
| drop_count | output | DROP_CNT_W | Saturating count of discarded words |

## Verification
The two functions that can fall in the same cycle are storing a producer word and removing a drain beat. The bench provokes this by filling the store completely and then starting a drain. It offers a new word in every beat cycle of that drain, so a store and a removal happen together at the full boundary. The result is judged at the ports: no drop is recorded, `in_ready` and `burst_avail` keep their full-state values, and the later drains return the surviving words and the new words in their exact order.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

    typedef enum logic [0:0] {
        DS_IDLE  = 1'b0,
        DS_DRAIN = 1'b1
    } drain_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bfw_store.sv
module bfw_store #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CAP_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PTR_W = bfw_pkg::idx_width(CAP_WORDS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(CAP_WORDS - 1);

    logic [DATA_W-1:0] mem_q [CAP_WORDS];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (rd_en) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    assign rd_data = mem_q[rd_ptr_q];

endmodule

// File: rtl/bfw_level.sv
module bfw_level #(
    parameter int unsigned CAP_WORDS = 16,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned HWM_WORDS = 12,
    localparam int unsigned OCC_W    = $clog2(CAP_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             burst_avail,
    output logic             in_ready
);
    localparam logic [OCC_W-1:0] CAP_V = OCC_W'(CAP_WORDS);
    localparam logic [OCC_W-1:0] BL_V  = OCC_W'(BURST_LEN);
    localparam logic [OCC_W-1:0] HWM_V = OCC_W'(HWM_WORDS);

    logic [OCC_W-1:0] occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_comb begin
        occ         = occ_q;
        full        = (occ_q == CAP_V);
        burst_avail = (occ_q >= BL_V);
        in_ready    = (occ_q < HWM_V);
    end

endmodule

// File: rtl/bfw_drain_fsm.sv
module bfw_drain_fsm
    import bfw_pkg::*;
#(
    parameter int unsigned BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drain_go,
    input  logic burst_avail,
    output logic pop,
    output logic out_valid,
    output logic out_last
);
    localparam int unsigned BEAT_W = idx_width(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    drain_state_e     state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            DS_IDLE: begin
                beat_d = '0;
                if (drain_go && burst_avail) begin
                    state_d = DS_DRAIN;
                end
            end
            DS_DRAIN: begin
                if (beat_q == LAST_BEAT) begin
                    state_d = DS_IDLE;
                    beat_d  = '0;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            default: begin
                state_d = DS_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            DS_IDLE: begin
                out_valid = 1'b0;
                out_last  = 1'b0;
            end
            DS_DRAIN: begin
                out_valid = 1'b1;
                out_last  = (beat_q == LAST_BEAT);
            end
            default: begin
                out_valid = 1'b0;
                out_last  = 1'b0;
            end
        endcase
        pop = out_valid;
    end

endmodule

// File: rtl/bfw_drop_mon.sv
module bfw_drop_mon #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop,
    output logic             drop_pulse,
    output logic             drop_sticky,
    output logic [CNT_W-1:0] drop_count
);
    logic             pulse_q;
    logic             sticky_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            pulse_q <= drop;
            if (drop) begin
                sticky_q <= 1'b1;
                if (cnt_q != {CNT_W{1'b1}}) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign drop_pulse  = pulse_q;
    assign drop_sticky = sticky_q;
    assign drop_count  = cnt_q;

endmodule

// File: rtl/burst_fifo_wm.sv
module burst_fifo_wm #(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned BURST_LEN    = 4,
    parameter int unsigned DEPTH_BURSTS = 4,
    parameter int unsigned HWM_BURSTS   = 3,
    parameter int unsigned DROP_CNT_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  in_ready,
    output logic                  burst_avail,
    input  logic                  drain_go,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_last,
    output logic                  drop_pulse,
    output logic                  drop_sticky,
    output logic [DROP_CNT_W-1:0] drop_count
);
    localparam int unsigned CAP_WORDS = DEPTH_BURSTS * BURST_LEN;
    localparam int unsigned HWM_WORDS = HWM_BURSTS * BURST_LEN;
    localparam int unsigned OCC_W     = $clog2(CAP_WORDS + 1);

    logic             pop;
    logic             full;
    logic             accept;
    logic             drop;
    logic [OCC_W-1:0] occ;

    // A beat leaving this cycle frees a slot, so a word arriving alongside it fits.
    assign accept = in_valid && (!full || pop);
    assign drop   = in_valid && full && !pop;

    bfw_store #(
        .DATA_W    (DATA_W),
        .CAP_WORDS (CAP_WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_en   (pop),
        .rd_data (out_data)
    );

    bfw_level #(
        .CAP_WORDS (CAP_WORDS),
        .BURST_LEN (BURST_LEN),
        .HWM_WORDS (HWM_WORDS)
    ) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (accept),
        .pop         (pop),
        .occ         (occ),
        .full        (full),
        .burst_avail (burst_avail),
        .in_ready    (in_ready)
    );

    bfw_drain_fsm #(
        .BURST_LEN (BURST_LEN)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .drain_go    (drain_go),
        .burst_avail (burst_avail),
        .pop         (pop),
        .out_valid   (out_valid),
        .out_last    (out_last)
    );

    bfw_drop_mon #(
        .CNT_W (DROP_CNT_W)
    ) u_drop (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop        (drop),
        .drop_pulse  (drop_pulse),
        .drop_sticky (drop_sticky),
        .drop_count  (drop_count)
    );

endmodule

// File: rtl/burst_fifo_wm_chk.sv
module burst_fifo_wm_chk #(
    parameter int unsigned CAP_WORDS    = 16,
    parameter int unsigned DEPTH_BURSTS = 4,
    parameter int unsigned HWM_BURSTS   = 3,
    parameter int unsigned DROP_CNT_W   = 8,
    parameter int unsigned OCC_W        = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  burst_avail,
    input logic                  drain_go,
    input logic                  out_valid,
    input logic                  out_last,
    input logic                  drop_pulse,
    input logic                  drop_sticky,
    input logic [DROP_CNT_W-1:0] drop_count,
    input logic [OCC_W-1:0]      occ
);
    initial begin
        a_r3_hwm_below_depth: assert (HWM_BURSTS >= 1 && HWM_BURSTS < DEPTH_BURSTS);
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CAP_WORDS));

    a_r5_drop_after_bp: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> $past(in_valid && !in_ready));

    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        drop_sticky |=> drop_sticky);

    a_r9_count_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != '0) |=> (drop_count >= $past(drop_count)));

    a_r3_ready_when_short: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_avail |-> in_ready);

    a_r6_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid);

    a_r7_start_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(drain_go && burst_avail));

endmodule

bind burst_fifo_wm burst_fifo_wm_chk #(
    .CAP_WORDS    (CAP_WORDS),
    .DEPTH_BURSTS (DEPTH_BURSTS),
    .HWM_BURSTS   (HWM_BURSTS),
    .DROP_CNT_W   (DROP_CNT_W),
    .OCC_W        (OCC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .burst_avail (burst_avail),
    .drain_go    (drain_go),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .drop_pulse  (drop_pulse),
    .drop_sticky (drop_sticky),
    .drop_count  (drop_count),
    .occ         (occ)
);

// File: tb/burst_fifo_wm_tb.sv
`timescale 1ns/1ps
module burst_fifo_wm_tb;
    localparam int DW  = 16;
    localparam int BL  = 4;
    localparam int DB  = 4;
    localparam int HB  = 3;
    localparam int CW  = 8;
    localparam int CAP = DB * BL;
    localparam int HWW = HB * BL;
    localparam int CNT_MAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          drain_go = 1'b0;
    logic          in_ready, burst_avail, out_valid, out_last;
    logic [DW-1:0] out_data;
    logic          drop_pulse, drop_sticky;
    logic [CW-1:0] drop_count;

    int checks = 0;
    int errors = 0;
    int word_seq = 1;
    bit sb_on = 1'b0;

    // bench-side model built from the requirements
    logic [DW-1:0] mq[$];
    int  m_left = 0;
    bit  m_drop = 1'b0;
    bit  m_sticky = 1'b0;
    int  m_cnt = 0;

    always #4 clk = ~clk;

    burst_fifo_wm #(
        .DATA_W(DW), .BURST_LEN(BL), .DEPTH_BURSTS(DB),
        .HWM_BURSTS(HB), .DROP_CNT_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .burst_avail(burst_avail), .drain_go(drain_go),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .drop_pulse(drop_pulse), .drop_sticky(drop_sticky), .drop_count(drop_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit pop_now, full_now, acc;
        if (!rst_n) begin
            mq.delete();
            m_left = 0; m_drop = 1'b0; m_sticky = 1'b0; m_cnt = 0;
        end else begin
            pop_now  = (m_left > 0);
            full_now = (mq.size() == CAP);
            acc      = in_valid && (!full_now || pop_now);
            m_drop   = in_valid && full_now && !pop_now;
            if (m_drop) begin
                m_sticky = 1'b1;
                if (m_cnt < CNT_MAX) m_cnt++;
            end
            if (pop_now) begin
                void'(mq.pop_front());
                m_left--;
            end else if (drain_go && mq.size() >= BL) begin
                m_left = BL;
            end
            if (acc) mq.push_back(in_data);
        end
    end

    // continuous scoreboard, sampled away from the rising edge
    always @(negedge clk) begin
        if (sb_on) begin
            check("R6 out_valid", 32'(out_valid), 32'(m_left > 0));
            if (m_left > 0) begin
                check("R10 out_data order", 32'(out_data), 32'(mq[0]));
                check("R6 out_last", 32'(out_last), 32'(m_left == 1));
            end
            check("R2 burst_avail", 32'(burst_avail), 32'(mq.size() >= BL));
            check("R3 in_ready", 32'(in_ready), 32'(mq.size() < HWW));
            check("R5 drop_pulse", 32'(drop_pulse), 32'(m_drop));
            check("R5 drop_sticky", 32'(drop_sticky), 32'(m_sticky));
            check("R9 drop_count", 32'(drop_count), 32'(m_cnt));
        end
    end

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(word_seq);
            word_seq++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_one();
        @(negedge clk);
        drain_go = 1'b1;
        @(negedge clk);
        drain_go = 1'b0;
        repeat (BL) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in_ready", 32'(in_ready), 32'd1);
        check("R1 burst_avail", 32'(burst_avail), 32'd0);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_last", 32'(out_last), 32'd0);
        check("R1 drop_pulse", 32'(drop_pulse), 32'd0);
        check("R1 drop_sticky", 32'(drop_sticky), 32'd0);
        check("R1 drop_count", 32'(drop_count), 32'd0);
        rst_n = 1'b1;
        sb_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_burst_avail();
        push_n(BL - 1);
        check("R2 partial burst", 32'(burst_avail), 32'd0);
        push_n(1);
        check("R2 full burst", 32'(burst_avail), 32'd1);
        drain_one();
        check("R2 after drain", 32'(burst_avail), 32'd0);
    endtask

    task automatic t_watermark();
        push_n(HWW - 1);
        check("R3 below watermark", 32'(in_ready), 32'd1);
        push_n(1);
        check("R3 at watermark", 32'(in_ready), 32'd0);
        push_n(CAP - HWW);
        check("R4 accepted past watermark", 32'(drop_count), 32'd0);
        check("R4 no drop past watermark", 32'(drop_sticky), 32'd0);
        push_n(1);
        check("R5 sticky after overflow", 32'(drop_sticky), 32'd1);
        check("R5 one drop counted", 32'(drop_count), 32'd1);
        drain_one();
        check("R3 still at watermark", 32'(in_ready), 32'd0);
        drain_one();
        check("R3 released below watermark", 32'(in_ready), 32'd1);
        drain_one();
        drain_one();
        check("R10 emptied", 32'(burst_avail), 32'd0);
    endtask

    task automatic t_ignore_go();
        int beats;
        push_n(BL - 2);
        @(negedge clk);
        drain_go = 1'b1;
        @(negedge clk);
        drain_go = 1'b0;
        check("R7 go ignored when short", 32'(out_valid), 32'd0);
        repeat (2) @(negedge clk);
        check("R7 still idle", 32'(out_valid), 32'd0);
        push_n(BL + 2);
        beats = 0;
        @(negedge clk);
        drain_go = 1'b1;
        for (int i = 0; i < 4 * BL; i++) begin
            @(negedge clk);
            if (out_valid) beats++;
            if (out_valid && out_last) begin
                drain_go = 1'b0;
                break;
            end
        end
        check("R7 held go keeps burst length", 32'(beats), 32'(BL));
        @(negedge clk);
        check("R6 gap after last beat", 32'(out_valid), 32'd0);
        drain_one();
    endtask

    task automatic t_overlap();
        int cnt_before;
        push_n(CAP);
        cnt_before = int'(drop_count);
        @(negedge clk);
        drain_go = 1'b1;
        @(negedge clk);
        drain_go = 1'b0;
        for (int i = 0; i < BL; i++) begin
            in_valid = 1'b1;
            in_data  = DW'(word_seq);
            word_seq++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R8 no drop on overlap", 32'(drop_count), 32'(cnt_before));
        check("R8 still full ready", 32'(in_ready), 32'd0);
        check("R8 still avail", 32'(burst_avail), 32'd1);
        for (int i = 0; i < DB; i++) drain_one();
    endtask

    task automatic t_saturate();
        push_n(CAP);
        push_n(CNT_MAX + 20);
        check("R9 count saturated", 32'(drop_count), 32'(CNT_MAX));
        check("R5 sticky kept", 32'(drop_sticky), 32'd1);
        for (int i = 0; i < DB; i++) drain_one();
        check("R10 drained after drops", 32'(burst_avail), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_burst_avail();
        t_watermark();
        t_ignore_go();
        t_overlap();
        t_saturate();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule